// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses the address of the next microinstruction in a microprogrammed control unit. It holds a 7-bit control address register that drives the address input of a 128-word control ROM. It also holds a single return-address register that supports one level of microcode subroutine nesting. On every enabled clock edge the register is loaded from one of four sources: the current address plus one, the branch target carried in the microinstruction, the saved return address, or an address built from the opcode of the fetched machine instruction.

The control unit supplies three things from the microinstruction it is executing: the 2-bit condition selector, the 2-bit branch kind and the 7-bit branch target. The datapath supplies the four opcode bits of the instruction word and three status flags: the indirect-address bit, the accumulator sign and the accumulator-is-zero flag. Each opcode owns a four-word routine slot in the lower half of the ROM. Execution starts at word 64, where the fetch routine lives.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the control address to 64 and clears the return register to 0. The reset takes priority over `en`.
- R2: While `en` is low and `rst` is low, a clock edge leaves both the control address and the return register unchanged.
- R3: `condSel` picks the test bit. 0 gives constant 1, 1 gives `indirBit`, 2 gives `accSign` and 3 gives `accZero`.
- R4: With `brKind` 0 (jump), a true test loads `brAddr`. A false test loads the current address plus one.
- R5: With `brKind` 1 (call), a true test loads `brAddr` and saves the current address plus one (modulo 128) into the return register. A false test loads the current address plus one and leaves the return register alone.
- R6: With `brKind` 2 (return), the address is loaded from the return register whatever the test result is.
- R7: With `brKind` 3 (map), the address becomes {0, `opBits`[3:0], 00}, which is 4 times the opcode. The test result is ignored.
- R8: The increment wraps: from address 127 the incremented address is 0.
- R9: The return register changes only on reset or on a call whose test is true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable |
| condSel | input | 2 | Test condition selector from the microinstruction |
| brKind | input | 2 | Branch kind: jump, call, return, map |
| brAddr | input | 7 | Branch target from the microinstruction |
| opBits | input | 4 | Opcode bits of the fetched instruction |
| indirBit | input | 1 | Indirect-address status bit |
| accSign | input | 1 | Accumulator sign bit |
| accZero | input | 1 | Accumulator equals zero |
| ctrlAddr | output | 7 | Current control memory address |

## Verification
A true call does two things on the same edge: it loads the branch target and it stores the incremented address. The hardest case is a call issued from address 127, where the saved value must wrap to 0 while the target is loaded. The bench jumps to 127, issues a call there, and then issues a return; it judges the case by checking that the return lands on 0. Random runs also place calls, returns and enable-low cycles next to each other, so that a return read in one cycle sees a save made in the cycle before.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    BR_JMP  = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } brKind_t;

  typedef enum logic [1:0] {
    SEL_INC  = 2'b00,
    SEL_JUMP = 2'b01,
    SEL_RET  = 2'b10,
    SEL_MAP  = 2'b11
  } nxtSel_t;

  typedef struct packed {
    nxtSel_t sel;
    logic    loadRet;
  } seqStrobe_t;

endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] condSel,
  input  logic [1:0] brKind,
  input  logic       indirBit,
  input  logic       accSign,
  input  logic       accZero,
  output seqStrobe_t stb
);

  logic testBit;

  always_comb begin
    unique case (condSel)
      2'd0:    testBit = 1'b1;
      2'd1:    testBit = indirBit;
      2'd2:    testBit = accSign;
      default: testBit = accZero;
    endcase
  end

  always_comb begin
    stb.loadRet = 1'b0;
    unique case (brKind_t'(brKind))
      BR_JMP:  stb.sel = testBit ? SEL_JUMP : SEL_INC;
      BR_CALL: begin
        stb.sel     = testBit ? SEL_JUMP : SEL_INC;
        stb.loadRet = testBit;
      end
      BR_RET:  stb.sel = SEL_RET;
      default: stb.sel = SEL_MAP;
    endcase
  end

  // R6
  ret_select_chk: assert property (@(posedge clk) disable iff (rst)
    (brKind == 2'b10) |-> (stb.sel == SEL_RET && !stb.loadRet));

  // R5
  call_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    stb.loadRet |-> (brKind == 2'b01 && stb.sel == SEL_JUMP));

  // R3
  uncond_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (condSel == 2'd0 && brKind == 2'b00) |-> (stb.sel == SEL_JUMP));

endmodule

// File: rtl/useq_dpath.sv
module useq_dpath
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OP_W       = 4,
  parameter int SLOT_LOG2  = 2,
  parameter int START_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] brAddr,
  input  logic [OP_W-1:0]   opBits,
  output logic [ADDR_W-1:0] carQ
);

  localparam logic [ADDR_W-1:0] StartVal = ADDR_W'(START_ADDR);
  localparam logic [ADDR_W-1:0] OneVal   = ADDR_W'(1);

  logic [ADDR_W-1:0] sbrQ;
  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] nextAddr;

  assign incAddr = carQ + OneVal;
  assign mapAddr = ADDR_W'(opBits) << SLOT_LOG2;

  always_comb begin
    unique case (stb.sel)
      SEL_INC:  nextAddr = incAddr;
      SEL_JUMP: nextAddr = brAddr;
      SEL_RET:  nextAddr = sbrQ;
      default:  nextAddr = mapAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carQ <= StartVal;
      sbrQ <= '0;
    end else if (en) begin
      carQ <= nextAddr;
      if (stb.loadRet) sbrQ <= incAddr;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(carQ) && $stable(sbrQ)));

  // R9
  ret_reg_guard_chk: assert property (@(posedge clk) disable iff (rst)
    !(en && stb.loadRet) |=> $stable(sbrQ));

  // R5
  call_save_chk: assert property (@(posedge clk) disable iff (rst)
    (en && stb.loadRet) |=> (sbrQ == ADDR_W'($past(carQ) + OneVal)));

  // R7
  map_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (en && stb.sel == SEL_MAP) |=> (carQ[ADDR_W-1] == 1'b0 && carQ[SLOT_LOG2-1:0] == '0));

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OP_W       = 4,
  parameter int START_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        condSel,
  input  logic [1:0]        brKind,
  input  logic [ADDR_W-1:0] brAddr,
  input  logic [OP_W-1:0]   opBits,
  input  logic              indirBit,
  input  logic              accSign,
  input  logic              accZero,
  output logic [ADDR_W-1:0] ctrlAddr
);

  seqStrobe_t stb;

  useq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .condSel(condSel), .brKind(brKind),
    .indirBit(indirBit), .accSign(accSign), .accZero(accZero), .stb(stb)
  );

  useq_dpath #(
    .ADDR_W(ADDR_W), .OP_W(OP_W), .SLOT_LOG2(2), .START_ADDR(START_ADDR)
  ) u_dpath (
    .clk(clk), .rst(rst), .en(en), .stb(stb),
    .brAddr(brAddr), .opBits(opBits), .carQ(ctrlAddr)
  );

endmodule

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
module sim_useq_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] condSel = '0;
  logic [1:0] brKind = '0;
  logic [6:0] brAddr = '0;
  logic [3:0] opBits = '0;
  logic       indirBit = 1'b0;
  logic       accSign = 1'b0;
  logic       accZero = 1'b0;
  logic [6:0] ctrlAddr;

  int nRun = 0;
  int nFail = 0;
  logic finished = 1'b0;
  logic [6:0] expCar = 7'd64;
  logic [6:0] expSbr = 7'd0;

  always #2 clk = ~clk;

  useq_top u0 (
    .clk(clk), .rst(rst), .en(en), .condSel(condSel), .brKind(brKind),
    .brAddr(brAddr), .opBits(opBits), .indirBit(indirBit),
    .accSign(accSign), .accZero(accZero), .ctrlAddr(ctrlAddr)
  );

  function automatic logic pickTest(logic [1:0] c, logic i, logic s, logic z);
    case (c)
      2'd0: return 1'b1;
      2'd1: return i;
      2'd2: return s;
      default: return z;
    endcase
  endfunction

  function automatic string reqTag(logic r, logic e, logic [1:0] b, logic [6:0] car, logic t);
    if (r) return "R1";
    if (!e) return "R2";
    case (b)
      2'd0: return (!t && car == 7'd127) ? "R8" : "R3/R4";
      2'd1: return (!t && car == 7'd127) ? "R8" : "R3/R5";
      2'd2: return "R6/R9";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input logic r, input logic e, input logic [1:0] c,
                      input logic [1:0] b, input logic [6:0] ad, input logic [3:0] op,
                      input logic i, input logic s, input logic z);
    logic t;
    string tag;
    @(negedge clk);
    rst = r; en = e; condSel = c; brKind = b; brAddr = ad; opBits = op;
    indirBit = i; accSign = s; accZero = z;
    t = pickTest(c, i, s, z);
    tag = reqTag(r, e, b, expCar, t);
    @(posedge clk);
    if (r) begin
      expCar = 7'd64; expSbr = 7'd0;
    end else if (e) begin
      case (b)
        2'd0: expCar = t ? ad : expCar + 7'd1;
        2'd1: begin
          if (t) begin expSbr = expCar + 7'd1; expCar = ad; end
          else expCar = expCar + 7'd1;
        end
        2'd2: expCar = expSbr;
        default: expCar = {1'b0, op, 2'b00};
      endcase
    end
    #1;
    nRun++;
    if (ctrlAddr !== expCar) begin
      nFail++;
      $display("FAIL %s: ctrlAddr=%0d expected=%0d", tag, ctrlAddr, expCar);
    end
  endtask

  initial begin
    void'($urandom(32'd5171));
    // R1 reset state
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 7'd9, 0, 0, 0, 0);
    // R6 / R1: return right after reset gives cleared register
    step(0, 1, 0, 2'd2, 7'd33, 0, 0, 0, 0);
    // R4 jump to 127, then R8 + R5: call there saves wrapped 0
    step(0, 1, 0, 2'd0, 7'd127, 0, 0, 0, 0);
    step(0, 1, 0, 2'd1, 7'd5, 0, 0, 0, 0);
    step(0, 1, 2'd1, 2'd0, 7'd77, 0, 0, 0, 0);
    step(0, 1, 0, 2'd2, 0, 0, 1, 1, 1);
    // R8 increment wrap with false jump test
    step(0, 1, 0, 2'd0, 7'd127, 0, 0, 0, 0);
    step(0, 1, 2'd2, 2'd0, 7'd11, 0, 0, 0, 0);
    // R2 disabled call changes nothing; then return proves register intact
    step(0, 1, 0, 2'd1, 7'd20, 0, 0, 0, 0);
    step(0, 0, 0, 2'd1, 7'd90, 0, 0, 0, 0);
    step(0, 0, 0, 2'd3, 0, 4'd7, 0, 0, 0);
    step(0, 1, 0, 2'd2, 0, 0, 0, 0, 0);
    // R9 false call leaves register; R3 each condition source
    step(0, 1, 2'd3, 2'd1, 7'd50, 0, 1, 1, 0);
    step(0, 1, 0, 2'd2, 0, 0, 0, 0, 0);
    step(0, 1, 2'd1, 2'd0, 7'd40, 0, 1, 0, 0);
    step(0, 1, 2'd2, 2'd0, 7'd41, 0, 0, 1, 0);
    step(0, 1, 2'd3, 2'd0, 7'd42, 0, 0, 0, 1);
    // R7 mapping extremes, test ignored
    step(0, 1, 2'd1, 2'd3, 7'd3, 4'd15, 0, 0, 0);
    step(0, 1, 0, 2'd3, 7'd3, 4'd0, 0, 0, 0);
    step(0, 1, 2'd2, 2'd3, 7'd3, 4'd9, 1, 1, 1);
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 100) == 0, ($urandom % 10) != 0, 2'($urandom), 2'($urandom),
           7'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule